// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Reload

This block is a byte-register timer/counter built from a low byte and a high byte. A two-bit mode field selects one of three counting layouts: a 13-bit count made of the five low bits of the low byte under the whole high byte, a full 16-bit count, or an 8-bit count in the low byte that reloads itself from the high byte. The fourth mode code holds the count.

Each count step comes from one of two sources. In timer operation the step is a clock-enable tick supplied from outside. In counter operation it is a falling edge detected on an external count pin after synchronisation. A run bit enables counting. A gate-select bit lets an external level pin qualify that run bit.

On rollover the block sets a sticky overflow flag. A registered interrupt request follows the flag while the interrupt is enabled. Software loads either byte through a shared write-data bus and clears the flag with a strobe.

Top module: `tmr_multimode`

## Requirements
- R1: While `rst` is high at a clock edge, `lo_q`, `hi_q`, `ovf_flag` and `irq` become 0.
- R2: With `mode` = 2'b00 each step increments the 13-bit value {`hi_q`, `lo_q[4:0]`}. `lo_q[7:5]` is never changed by a step. A step from 13'h1FFF gives 0 and an overflow.
- R3: With `mode` = 2'b01 each step increments {`hi_q`, `lo_q`} as a 16-bit value. A step from 16'hFFFF gives 16'h0000 and an overflow.
- R4: With `mode` = 2'b10 each step increments `lo_q`. A step while `lo_q` = 8'hFF loads `lo_q` from `hi_q` and signals an overflow. `hi_q` changes only through a write.
- R5: With `mode` = 2'b11 steps have no effect on `lo_q` or `hi_q`.
- R6: With `ct_sel` = 0 a step is a clock edge where `tick_en` is high, and `cnt_pin` is ignored. With `ct_sel` = 1 `tick_en` is ignored and each falling edge on `cnt_pin` gives exactly one step. That step lands on the third rising clock edge after `cnt_pin` is first sampled low.
- R7: A step is taken only when `run` = 1 and either `gate_sel` = 0 or `gate_pin` = 1. Otherwise the count holds.
- R8: An overflow sets `ovf_flag`. The flag stays set until a cycle with `flag_clr` = 1 clears it. If an overflow and `flag_clr` fall in the same cycle, the flag ends set.
- R9: `irq` is registered and equals, after each edge, the new `ovf_flag` ANDed with `irq_en` as sampled at that edge.
- R10: `lo_wr` loads `wr_data` into `lo_q` and `hi_wr` loads it into `hi_q`. In a cycle with either write, the count step and any overflow of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled clock enable used as the timer step |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate level |
| run | input | 1 | Run control |
| gate_sel | input | 1 | 1: gate_pin qualifies run |
| ct_sel | input | 1 | 0: timer ticks, 1: count-pin falling edges |
| mode | input | 2 | 00 13-bit, 01 16-bit, 10 8-bit reload, 11 hold |
| irq_en | input | 1 | Interrupt enable |
| lo_wr | input | 1 | Write strobe for the low byte |
| hi_wr | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Overflow flag clear strobe |
| lo_q | output | 8 | Low byte |
| hi_q | output | 8 | High byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an overflow that lands in the same cycle as a flag clear. Close behind it is an overflow that a byte write cancels. Both need the count placed one step short of rollover, with the second strobe timed to that exact edge. The directed stimulus loads both bytes with the run bit off, then turns on run and the strobe together for one cycle. After that, a long randomized stretch keeps re-priming the bytes near their limits under all modes, gate levels and pin patterns. A behavioural reference model is compared against the outputs every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_13B  = 2'b00,
    MODE_16B  = 2'b01,
    MODE_RLD8 = 2'b10,
    MODE_HOLD = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

  // R6: one falling edge produces a single-cycle step request
  p_fall_single_r6: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tmr_step_gen.sv
module tmr_step_gen (
  input  logic tick_en,
  input  logic fall,
  input  logic run,
  input  logic gate_sel,
  input  logic gate_pin,
  input  logic ct_sel,
  output logic step
);
  logic enabled;
  logic source;

  always_comb begin
    enabled = run & (~gate_sel | gate_pin);
    source  = ct_sel ? fall : tick_en;
    step    = enabled & source;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  tmr_mode_e         mode,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              ovf
);
  localparam int W13 = DATA_W + PRE_W;
  localparam int W16 = 2 * DATA_W;

  logic [W13:0]      w13;
  logic [W16:0]      w16;
  logic [DATA_W:0]   w8;
  logic [DATA_W-1:0] lo_n, hi_n;
  logic              wr_any;

  assign wr_any = lo_wr | hi_wr;

  always_comb begin
    w13  = {1'b0, hi_q, lo_q[PRE_W-1:0]} + {{W13{1'b0}}, 1'b1};
    w16  = {1'b0, hi_q, lo_q} + {{W16{1'b0}}, 1'b1};
    w8   = {1'b0, lo_q} + {{DATA_W{1'b0}}, 1'b1};
    lo_n = lo_q;
    hi_n = hi_q;
    ovf  = 1'b0;
    if (wr_any) begin
      if (lo_wr) lo_n = wr_data;
      if (hi_wr) hi_n = wr_data;
    end else if (step) begin
      unique case (mode)
        MODE_13B: begin
          lo_n = {lo_q[DATA_W-1:PRE_W], w13[PRE_W-1:0]};
          hi_n = w13[W13-1:PRE_W];
          ovf  = w13[W13];
        end
        MODE_16B: begin
          lo_n = w16[DATA_W-1:0];
          hi_n = w16[W16-1:DATA_W];
          ovf  = w16[W16];
        end
        MODE_RLD8: begin
          ovf  = w8[DATA_W];
          lo_n = w8[DATA_W] ? hi_q : w8[DATA_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  p_upper_held_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_13B && !lo_wr) |=> lo_q[DATA_W-1:PRE_W] == $past(lo_q[DATA_W-1:PRE_W]));
  p_reload_hi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RLD8 && !hi_wr) |=> $stable(hi_q));
  p_reload_value_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RLD8 && ovf) |=> lo_q == $past(hi_q));
  p_hold_mode_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));
  p_write_lo_r10: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> lo_q == $past(wr_data));
  p_write_hi_r10: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> hi_q == $past(wr_data));
endmodule

// File: rtl/tmr_flag_irq.sv
module tmr_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic flag_clr,
  input  logic irq_en,
  output logic ovf_flag,
  output logic irq
);
  logic flag_n;

  always_comb begin
    if (ovf)           flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else               flag_n = ovf_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ovf_flag <= flag_n;
      irq      <= flag_n & irq_en;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf_flag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ovf) |=> !ovf_flag);
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
endmodule

// File: rtl/tmr_multimode.sv
module tmr_multimode
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              run,
  input  logic              gate_sel,
  input  logic              ct_sel,
  input  logic [1:0]        mode,
  input  logic              irq_en,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              ovf_flag,
  output logic              irq
);
  logic fall, step, ovf;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(fall)
  );

  tmr_step_gen u_step (
    .tick_en(tick_en), .fall(fall), .run(run), .gate_sel(gate_sel),
    .gate_pin(gate_pin), .ct_sel(ct_sel), .step(step)
  );

  tmr_count_core #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_core (
    .clk(clk), .rst(rst), .step(step), .mode(tmr_mode_e'(mode)),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data),
    .lo_q(lo_q), .hi_q(hi_q), .ovf(ovf)
  );

  tmr_flag_irq u_flag (
    .clk(clk), .rst(rst), .ovf(ovf), .flag_clr(flag_clr), .irq_en(irq_en),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  p_gated_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((!run || (gate_sel && !gate_pin)) && !lo_wr && !hi_wr)
      |=> ($stable(lo_q) && $stable(hi_q)));
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (lo_q == '0 && hi_q == '0 && !ovf_flag && !irq));
endmodule

// File: tb/tb_tmr_multimode.sv
module tb_tmr_multimode;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 0, cnt_pin = 0, gate_pin = 0, run = 0, gate_sel = 0, ct_sel = 0;
  logic [1:0] mode = 2'b00;
  logic irq_en = 0, lo_wr = 0, hi_wr = 0, flag_clr = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] lo_q, hi_q;
  logic ovf_flag, irq;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;
  bit done = 0;
  string phase = "R1";

  int m_lo = 0, m_hi = 0, m_flag = 0, m_irq = 0;
  int hist[$] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_multimode dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .run(run), .gate_sel(gate_sel), .ct_sel(ct_sel), .mode(mode), .irq_en(irq_en),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .wr_data(wr_data), .flag_clr(flag_clr),
    .lo_q(lo_q), .hi_q(hi_q), .ovf_flag(ovf_flag), .irq(irq)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_lo = 0; m_hi = 0; m_flag = 0; m_irq = 0;
      hist = '{0, 0, 0};
    end else begin
      bit fall, stp, ov;
      int v;
      fall = (hist[2] == 1) && (hist[1] == 0);
      stp = run && (!gate_sel || gate_pin) && (ct_sel ? fall : tick_en);
      ov = 0;
      if (lo_wr || hi_wr) begin
        if (lo_wr) m_lo = int'(wr_data);
        if (hi_wr) m_hi = int'(wr_data);
      end else if (stp) begin
        case (mode)
          2'b00: begin
            v = m_hi * 32 + (m_lo % 32) + 1;
            if (v == 8192) begin v = 0; ov = 1; end
            m_hi = v / 32;
            m_lo = (m_lo / 32) * 32 + (v % 32);
          end
          2'b01: begin
            v = m_hi * 256 + m_lo + 1;
            if (v == 65536) begin v = 0; ov = 1; end
            m_hi = v / 256;
            m_lo = v % 256;
          end
          2'b10: begin
            if (m_lo == 255) begin m_lo = m_hi; ov = 1; end
            else m_lo = m_lo + 1;
          end
          default: ;
        endcase
      end
      if (ov) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_irq = (m_flag == 1 && irq_en) ? 1 : 0;
      hist.push_front(int'(cnt_pin));
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk({phase, " model lo_q"}, int'(lo_q), m_lo);
      chk({phase, " model hi_q"}, int'(hi_q), m_hi);
      chk({phase, " model ovf_flag"}, int'(ovf_flag), m_flag);
      chk({phase, " model irq"}, int'(irq), m_irq);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit to_hi, logic [7:0] v);
    lo_wr = !to_hi; hi_wr = to_hi; wr_data = v;
    cyc();
    lo_wr = 0; hi_wr = 0;
  endtask

  initial begin
    cyc(3);
    chk("R1 reset lo_q", int'(lo_q), 0);
    chk("R1 reset hi_q", int'(hi_q), 0);
    chk("R1 reset flag", int'(ovf_flag), 0);
    rst = 0;
    cmp_on = 1;
    cyc();

    phase = "R3";
    mode = 2'b01;
    wr(0, 8'hFD); wr(1, 8'hFF);
    run = 1; tick_en = 1;
    cyc(3);
    run = 0;
    chk("R3 wrap lo_q", int'(lo_q), 0);
    chk("R3 wrap hi_q", int'(hi_q), 0);
    chk("R3 wrap flag", int'(ovf_flag), 1);

    phase = "R8";
    flag_clr = 1; cyc(); flag_clr = 0;
    chk("R8 cleared", int'(ovf_flag), 0);
    wr(0, 8'hFF); wr(1, 8'hFF);
    run = 1; flag_clr = 1;
    cyc();
    run = 0; flag_clr = 0;
    chk("R8 overflow beats clear", int'(ovf_flag), 1);

    phase = "R9";
    irq_en = 1; cyc();
    chk("R9 irq on", int'(irq), 1);
    irq_en = 0; cyc();
    chk("R9 irq off", int'(irq), 0);

    phase = "R2";
    flag_clr = 1; cyc(); flag_clr = 0;
    mode = 2'b00;
    wr(0, 8'hFE); wr(1, 8'hFF);
    run = 1;
    cyc(2);
    run = 0;
    chk("R2 lo_q upper held", int'(lo_q), 8'hE0);
    chk("R2 hi_q wrap", int'(hi_q), 0);
    chk("R2 flag", int'(ovf_flag), 1);

    phase = "R4";
    mode = 2'b10;
    wr(1, 8'hF0); wr(0, 8'hFE);
    run = 1;
    cyc(3);
    run = 0;
    chk("R4 reload lo_q", int'(lo_q), 8'hF1);
    chk("R4 hi_q kept", int'(hi_q), 8'hF0);

    phase = "R5";
    mode = 2'b11; run = 1;
    cyc(4);
    chk("R5 hold lo_q", int'(lo_q), 8'hF1);

    phase = "R7";
    mode = 2'b01; gate_sel = 1; gate_pin = 0;
    cyc(3);
    chk("R7 gated lo_q", int'(lo_q), 8'hF1);
    gate_pin = 1;
    cyc(2);
    chk("R7 gate open lo_q", int'(lo_q), 8'hF3);

    phase = "R6";
    gate_sel = 0; ct_sel = 1; cnt_pin = 1;
    cyc(3);
    chk("R6 ticks ignored", int'(lo_q), 8'hF3);
    cnt_pin = 0;
    cyc(2);
    chk("R6 before third edge", int'(lo_q), 8'hF3);
    cyc(3);
    chk("R6 one count per fall", int'(lo_q), 8'hF4);
    cnt_pin = 1; cyc(2); cnt_pin = 0; cyc(5);
    chk("R6 second fall", int'(lo_q), 8'hF5);

    phase = "R10";
    ct_sel = 0; tick_en = 1; run = 1;
    lo_wr = 1; wr_data = 8'h10;
    cyc();
    lo_wr = 0;
    chk("R10 write beats step", int'(lo_q), 8'h10);
    chk("R10 hi_q untouched", int'(hi_q), 8'hF0);
    cyc();
    chk("R10 resume", int'(lo_q), 8'h11);

    phase = "R6/R7 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      mode = 2'($urandom % 4);
      run = ($urandom % 8) != 0;
      gate_sel = ($urandom % 3) == 0;
      gate_pin = ($urandom % 2) == 0;
      ct_sel = ($urandom % 3) == 0;
      tick_en = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) cnt_pin = ~cnt_pin;
      irq_en = ($urandom % 2) == 0;
      flag_clr = ($urandom % 10) == 0;
      lo_wr = r < 4;
      hi_wr = (r >= 3) && (r < 6);
      wr_data = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
      cyc();
    end
    lo_wr = 0; hi_wr = 0; run = 0;
    cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule